// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block owns the SDRAM command bus from the moment reset is released until the memory is ready for normal traffic. For a programmable power-up interval it drives only the no-operation command. It then puts every bank of the rank into idle with a precharge-all, gives eight auto-refresh commands, and loads the mode register with a word that carries the chosen CAS latency. Each command is followed by a programmable settling time.

When the board has two ranks, the whole precharge, refresh and mode-load sequence runs again with the rank select pointing at the second rank. The long power-up wait is not repeated. Once the last rank has settled, `init_done` rises. The block then switches to a periodic refresh generator. That generator divides the clock into a tick of roughly one microsecond and issues a refresh every `refresh_cnt + 1` ticks, to each populated rank in turn. It also outputs the read-to-precharge spacing that the controller derives from the CAS latency. The configuration inputs are expected to stay stable while reset is deasserted.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and for exactly PWRUP_CYC clock cycles after reset is released, the command bus carries NOP and `init_done` is low.
- R2: The command order is precharge-all, then eight auto-refresh, then mode-register load. The second command follows the first by T_RP cycles. Each refresh follows the previous one by T_RFC cycles. The mode load follows the eighth refresh by T_RFC cycles.
- R3: The commands on {cs_n, ras_n, cas_n, we_n} are encoded as NOP=0111, precharge=0010, refresh=0001 and mode load=0000. Precharge-all drives address bit 10 high and every other address bit low. Refresh drives the address to zero.
- R4: During the mode load, the address carries the effective CAS latency in bits 6:4 and the value 010 (burst of four) in bits 2:0. All other bits are zero.
- R5: A CAS latency input below 2 is treated as 2.
- R6: `rd_to_pre` equals the effective CAS latency minus one.
- R7: With `two_ranks` high, the rank-1 precharge-all (rank_sel=1) follows the rank-0 mode load by T_MRD cycles, and the full sequence repeats on rank 1. With `two_ranks` low, rank_sel never goes to 1 while a command is issued.
- R8: `init_done` rises T_MRD cycles after the last rank's mode load and stays high until reset.
- R9: After `init_done` rises, a refresh to rank 0 is issued every (refresh_cnt+1)*TICK_DIV cycles. The first one comes that many cycles after `init_done` rises.
- R10: With two ranks, each periodic refresh to rank 0 is followed on the next cycle by a refresh to rank 1.
- R11: Once `init_done` is high, only NOP and refresh appear on the command bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 3 | Requested CAS latency |
| two_ranks | input | 1 | High when a second rank is fitted |
| refresh_cnt | input | PERIOD_W | Refresh period in ticks minus one |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| rank_sel | output | 1 | Rank addressed by the current command |
| rd_to_pre | output | 3 | Read-to-precharge spacing in cycles |
| init_done | output | 1 | Initialization complete |

## Verification
The assertions are evaluated on every cycle. They check that no command other than NOP appears before the power-up interval has elapsed, that precharge always raises address bit 10, and that the mode word never carries a latency below two. They also check that rank 1 is never addressed on a single-rank board, that `init_done` never falls, and that after completion only refresh or NOP is issued. Only the bench's scoreboard scenarios can show the exact cycle of every command, the full ordering, the repetition on the second rank, and the spacing of periodic refresh for different period counts and latencies.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W    = 13,
  parameter int PWRUP_CYC = 12500,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 9,
  parameter int T_MRD     = 2,
  parameter int REF_BURST = 8,
  parameter int TICK_DIV  = 125,
  parameter int PERIOD_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cas_lat,
  input  logic                two_ranks,
  input  logic [PERIOD_W-1:0] refresh_cnt,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ADDR_W-1:0]   addr,
  output logic                rank_sel,
  output logic [2:0]          rd_to_pre,
  output logic                init_done
);

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam int WAIT_A   = (PWRUP_CYC > T_RFC) ? PWRUP_CYC : T_RFC;
  localparam int WAIT_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int WAIT_MAX = (WAIT_A > WAIT_B) ? WAIT_A : WAIT_B;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam int RC_W     = $clog2(REF_BURST + 1);
  localparam int TD_W     = $clog2(TICK_DIV + 1);

  localparam logic [ADDR_W-1:0] A10_ONLY = ADDR_W'(1) << 10;

  typedef enum logic [2:0] {S_PWR, S_PREW, S_REFW, S_MRSW, S_RUN, S_REF2} st_t;

  st_t                 st;
  logic [CNT_W-1:0]    cnt;
  logic [RC_W-1:0]     rc;
  logic [TD_W-1:0]     tdiv;
  logic [PERIOD_W-1:0] pcnt;
  logic [3:0]          cmd;

  logic [2:0] eff_cl;
  logic       tick;
  logic [ADDR_W-1:0] mode_word;

  assign eff_cl    = (cas_lat < 3'd2) ? 3'd2 : cas_lat;
  assign rd_to_pre = eff_cl - 3'd1;
  assign mode_word = ADDR_W'({eff_cl, 4'b0010});
  assign tick      = init_done && (tdiv == TD_W'(TICK_DIV - 1));
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWR;
      cnt       <= '0;
      rc        <= '0;
      cmd       <= CMD_NOP;
      addr      <= '0;
      rank_sel  <= 1'b0;
      init_done <= 1'b0;
      tdiv      <= '0;
      pcnt      <= '0;
    end else begin
      cmd  <= CMD_NOP;
      addr <= '0;
      case (st)
        S_PWR: begin
          if (cnt == CNT_W'(PWRUP_CYC - 1)) begin
            cmd  <= CMD_PRE;
            addr <= A10_ONLY;
            cnt  <= '0;
            st   <= S_PREW;
          end else cnt <= cnt + 1'b1;
        end
        S_PREW: begin
          if (cnt == CNT_W'(T_RP - 1)) begin
            cmd <= CMD_REF;
            cnt <= '0;
            rc  <= '0;
            st  <= S_REFW;
          end else cnt <= cnt + 1'b1;
        end
        S_REFW: begin
          if (cnt == CNT_W'(T_RFC - 1)) begin
            cnt <= '0;
            if (rc == RC_W'(REF_BURST - 1)) begin
              cmd  <= CMD_MRS;
              addr <= mode_word;
              st   <= S_MRSW;
            end else begin
              cmd <= CMD_REF;
              rc  <= rc + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_MRSW: begin
          if (cnt == CNT_W'(T_MRD - 1)) begin
            cnt <= '0;
            if (!rank_sel && two_ranks) begin
              rank_sel <= 1'b1;
              cmd      <= CMD_PRE;
              addr     <= A10_ONLY;
              st       <= S_PREW;
            end else begin
              rank_sel  <= 1'b0;
              init_done <= 1'b1;
              tdiv      <= '0;
              pcnt      <= '0;
              st        <= S_RUN;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RUN: begin
          if (tick && pcnt == refresh_cnt) begin
            cmd      <= CMD_REF;
            rank_sel <= 1'b0;
            if (two_ranks) st <= S_REF2;
          end
        end
        S_REF2: begin
          cmd      <= CMD_REF;
          rank_sel <= 1'b1;
          st       <= S_RUN;
        end
        default: st <= S_PWR;
      endcase
      if (init_done) begin
        tdiv <= tick ? '0 : tdiv + 1'b1;
        if (tick) pcnt <= (pcnt == refresh_cnt) ? '0 : pcnt + 1'b1;
      end
    end
  end

  logic [CNT_W-1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != CNT_W'(PWRUP_CYC)) up_cnt <= up_cnt + 1'b1;
  end

  // R1
  pwrup_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |-> (up_cnt >= CNT_W'(PWRUP_CYC)));

  // R3
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> addr[10]);

  // R5
  mode_cl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |-> (addr[6:4] >= 3'd2));

  // R7
  single_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_ranks && cmd != CMD_NOP) |-> !rank_sel);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R11
  run_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == CMD_NOP || cmd == CMD_REF));

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int AW = 13, PW = 200, TRP = 3, TRFC = 7, TMRD = 2, TD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cas_lat = 3'd3;
  logic two_ranks = 1'b0;
  logic [7:0] refresh_cnt = 8'd2;
  logic cs_n, ras_n, cas_n, we_n, rank_sel, init_done;
  logic [AW-1:0] addr;
  logic [2:0] rd_to_pre;

  always #4 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .PWRUP_CYC(PW), .T_RP(TRP), .T_RFC(TRFC),
                   .T_MRD(TMRD), .REF_BURST(8), .TICK_DIV(TD), .PERIOD_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .two_ranks(two_ranks),
    .refresh_cnt(refresh_cnt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .rank_sel(rank_sel), .rd_to_pre(rd_to_pre),
    .init_done(init_done));

  int n_vec = 0, n_bad = 0;
  int cyc;
  int done_cyc;
  bit done_seen;
  logic [49:0] expq[$];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic [49:0] mk(int t, logic [3:0] c, logic r, logic [AW-1:0] a);
    return {32'(t), c, r, a};
  endfunction

  // driver: R2 R3 R4 R7 R9 R10 expected command stream
  task automatic plan(input bit two, input int cl, input int rc, input int nper,
                      output int done_exp, output int last);
    int t = PW;
    logic [2:0] ecl = (cl < 2) ? 3'd2 : 3'(cl);
    for (int r = 0; r < (two ? 2 : 1); r++) begin
      expq.push_back(mk(t, 4'b0010, 1'(r), AW'(1) << 10));
      t += TRP;
      for (int i = 0; i < 8; i++) begin
        expq.push_back(mk(t, 4'b0001, 1'(r), '0));
        t += TRFC;
      end
      expq.push_back(mk(t, 4'b0000, 1'(r), AW'({ecl, 4'b0010})));
      t += TMRD;
    end
    done_exp = t;
    for (int k = 0; k < nper; k++) begin
      t += (rc + 1) * TD;
      expq.push_back(mk(t, 4'b0001, 1'b0, '0));
      if (two) expq.push_back(mk(t + 1, 4'b0001, 1'b1, '0));
    end
    last = t + 1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (init_done && !done_seen) begin done_seen = 1; done_cyc = cyc; end
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        logic [49:0] got, exp;
        got = mk(cyc, {cs_n, ras_n, cas_n, we_n}, rank_sel, addr);
        n_vec++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R11 R2 unexpected command: got %h expected none", got);
        end else begin
          exp = expq.pop_front();
          if (got !== exp) begin
            n_bad++;
            $display("FAIL R2 R3 R4 R7 R9 R10 cmd stream: got cyc=%0d cmd=%b rk=%b a=%h expected cyc=%0d cmd=%b rk=%b a=%h",
              got[49:18], got[17:14], got[13], got[12:0], exp[49:18], exp[17:14], exp[13], exp[12:0]);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic scenario(input bit two, input int cl, input int rc, input int nper);
    int dexp, last;
    rst_n = 1'b0;
    two_ranks = two; cas_lat = 3'(cl); refresh_cnt = 8'(rc);
    expq.delete(); done_seen = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 reset cmd", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(init_done == 1'b0, "R1 reset done", int'(init_done), 0);
    // R6 R5
    chk(rd_to_pre == ((cl < 2) ? 3'd1 : 3'(cl - 1)), "R6 rd_to_pre", int'(rd_to_pre), (cl < 2) ? 1 : cl - 1);
    plan(two, cl, rc, nper, dexp, last);
    rst_n = 1'b1;
    while (cyc < last + 3) @(negedge clk);
    chk(expq.size() == 0, "R9 missing commands", expq.size(), 0);
    chk(done_seen && done_cyc == dexp, "R8 done cycle", done_cyc, dexp);
    chk(init_done == 1'b1, "R8 done held", int'(init_done), 1);
  endtask

  initial begin
    scenario(1'b0, 3, 2, 3);
    scenario(1'b1, 1, 0, 4);   // R5 clamp, R7 R10
    scenario(1'b1, 2, 4, 2);
    scenario(1'b0, 0, 1, 2);   // R5
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule